// File: doc/BRIEF.md
# Constant-Geometry Radix-2 FFT Engine

This block computes an N-point complex discrete Fourier transform with a single shared butterfly. It uses the constant-geometry form of the radix-2 decimation-in-frequency algorithm. Every pass reads its operands from the same two address positions, k and k+N/2, and writes its results to positions 2k and 2k+1. Because of this, one butterfly, one complex multiplier (four real multipliers) and one address generator serve every pass. The algorithm is not in place, so two complete N-word buffers take turns: one pass reads from one buffer and writes into the other.

A frame is loaded in natural order through a valid/ready input port, one complex sample per cycle. The engine then runs log2(N) passes of N cycles each and streams the N results through a valid/data/last port with no backpressure. The output grows by one bit per pass and is never scaled. A build parameter sets whether results leave in natural bin order or in bit-reversed order. A full frame occupies N·(log2(N)+2) cycles, and the next frame can start loading on the cycle that carries the last result.

Top module: `cgfft_core`

## Requirements
- R1: The reset is synchronous and active low. On the cycle after a reset edge, in_ready is 1, out_valid is 0 and out_last is 0.
- R2: A sample is taken on each rising edge where in_valid and in_ready are both 1. The k-th sample taken is input index k, for k from 0 to N-1. From the cycle after the N-th sample is taken, in_ready stays 0 until the cycle that carries that frame's last result.
- R3: in_valid has no effect while in_ready is 0. The results of the frame then equal those of the same frame loaded without the extra in_valid pulses.
- R4: The first result is valid in the cycle after the (log2(N)·N+1)-th rising edge that follows the edge taking the last input sample. The N results occupy N consecutive valid cycles, and out_last is 1 only together with the N-th result.
- R5: In each pass s (0-based), butterfly k takes a=x[k] and b=x[k+N/2]. It writes a+b to position 2k. It writes (a-b)·W to position 2k+1, where W has index ((k>>s)<<s). Each real part of the product is rounded as floor((p + 2^(TW-3)) / 2^(TW-2)). Twiddle entry j is round(2^(TW-2)·cos(2πj/N)) − i·round(2^(TW-2)·sin(2πj/N)).
- R6: Outputs are DW+log2(N) bits wide, two's complement, and unscaled. A constant input of −2^(DW-1)+0i yields −N·2^(DW-1) in bin 0 and zero in every other bin.
- R7: With NAT_ORDER=1, the m-th result of a frame is bin m. With NAT_ORDER=0, the m-th result is bin bitrev(m), where bitrev reverses the log2(N) index bits. As a result, bin 1 appears at position N/2.
- R8: in_ready is 1 in the same cycle as out_last, so frames can follow each other back to back with a period of N·(log2(N)+2) cycles.
- R9: A reset applied in the middle of loading discards the partial frame and restores the R1 state. The next full frame then transforms correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Engine is in its loading phase and takes samples |
| in_re | input | DW | Input real part, two's complement |
| in_im | input | DW | Input imaginary part, two's complement |
| out_valid | output | 1 | Result present |
| out_last | output | 1 | Final result of the frame |
| out_re | output | DW+N_LOG2 | Result real part, two's complement |
| out_im | output | DW+N_LOG2 | Result imaginary part, two's complement |

## Verification
The bench builds two instances side by side. The first uses the defaults (N=16, natural output order, 8-bit data, 10-bit twiddles). The second uses N=8 with bit-reversed output. Together they cover both pass parities, so the final data lands in a different buffer in each case, and both branches of the output reordering are exercised. The 16-point build makes the full-scale constant input reach exactly the most negative output code. The 8-point build shows a single tone at position N/2, which only the bit-reversed path produces.

// File: rtl/cgfft_pkg.sv
// Package cgfft_pkg
// Holds the engine's phase encoding and the helper functions that produce
// the quantized twiddle factors. It assumes the twiddle scale passed in is a
// power of two no larger than the signed range of the twiddle word.
package cgfft_pkg;

    typedef enum logic [1:0] {
        PH_LOAD  = 2'd0,
        PH_CALC  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_t;

    // Real part of twiddle j: round(q * cos(2*pi*j/n)).
    function automatic int twq_re(input int j, input int n, input int q);
        real ang;
        ang = 6.283185307179586 * real'(j) / real'(n);
        return $rtoi($floor(real'(q) * $cos(ang) + 0.5));
    endfunction

    // Imaginary part of twiddle j: round(-q * sin(2*pi*j/n)).
    function automatic int twq_im(input int j, input int n, input int q);
        real ang;
        ang = 6.283185307179586 * real'(j) / real'(n);
        return $rtoi($floor(-real'(q) * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/cgfft_twiddle_rom.sv
// Module cgfft_twiddle_rom
// Holds a table of N/2 complex twiddle factors, computed at elaboration, and
// returns one entry combinationally. Unity is scaled to 2^(TW-2), so TW must
// be at least 3. The index width matches the table exactly.
module cgfft_twiddle_rom #(
    parameter int N_LOG2 = 4,
    parameter int TW     = 10
) (
    input  logic [N_LOG2-2:0]     idx,
    output logic signed [TW-1:0]  w_re,
    output logic signed [TW-1:0]  w_im
);
    localparam int N    = 1 << N_LOG2;
    localparam int HALF = N / 2;
    localparam int QS   = 1 << (TW - 2);

    logic [TW-1:0] tab_re [HALF];
    logic [TW-1:0] tab_im [HALF];

    // One constant entry per twiddle index.
    for (genvar j = 0; j < HALF; j++) begin : g_tab
        assign tab_re[j] = TW'(cgfft_pkg::twq_re(j, N, QS));
        assign tab_im[j] = TW'(cgfft_pkg::twq_im(j, N, QS));
    end

    // Table lookup.
    assign w_re = tab_re[idx];
    assign w_im = tab_im[idx];

endmodule

// File: rtl/cgfft_butterfly.sv
// Module cgfft_butterfly
// A combinational radix-2 butterfly. It returns either the sum a+b or the
// difference (a-b) multiplied by twiddle w, using four real multipliers and
// round-half-up rescaling by 2^(TW-2). It assumes that operand magnitudes
// leave room for one bit of growth, so the sum and the product fit in OW bits.
module cgfft_butterfly #(
    parameter int OW = 12,
    parameter int TW = 10
) (
    input  logic signed [OW-1:0] a_re,
    input  logic signed [OW-1:0] a_im,
    input  logic signed [OW-1:0] b_re,
    input  logic signed [OW-1:0] b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    input  logic                 take_diff,
    output logic signed [OW-1:0] y_re,
    output logic signed [OW-1:0] y_im
);
    localparam int PW = OW + TW + 1;
    localparam int SH = TW - 2;
    localparam logic signed [PW-1:0] RND = {{(PW-1){1'b0}}, 1'b1} << (TW - 3);

    logic signed [OW-1:0] s_re, s_im, d_re, d_im;
    logic signed [PW-1:0] dxr, dxi, wxr, wxi;
    logic signed [PW-1:0] p_re, p_im, r_re, r_im;

    // Sum and difference branches.
    always_comb begin
        s_re = a_re + b_re;
        s_im = a_im + b_im;
        d_re = a_re - b_re;
        d_im = a_im - b_im;
    end

    // Complex product of the difference with the twiddle, then rounding.
    always_comb begin
        dxr  = {{(PW-OW){d_re[OW-1]}}, d_re};
        dxi  = {{(PW-OW){d_im[OW-1]}}, d_im};
        wxr  = {{(PW-TW){w_re[TW-1]}}, w_re};
        wxi  = {{(PW-TW){w_im[TW-1]}}, w_im};
        p_re = dxr * wxr - dxi * wxi;
        p_im = dxr * wxi + dxi * wxr;
        r_re = (p_re + RND) >>> SH;
        r_im = (p_im + RND) >>> SH;
    end

    // Branch select: even write positions take the sum, odd ones the product.
    always_comb begin
        if (take_diff) begin
            y_re = r_re[OW-1:0];
            y_im = r_im[OW-1:0];
        end else begin
            y_re = s_re;
            y_im = s_im;
        end
    end

endmodule

// File: rtl/cgfft_pingpong.sv
// Module cgfft_pingpong
// Two equal banks of DEPTH words. A single write port selects its bank with
// wr_bank. Two asynchronous read ports share the bank chosen by rd_bank. The
// module assumes that the controller never reads and writes the same bank in
// one pass.
module cgfft_pingpong #(
    parameter int AW = 4,
    parameter int W  = 24
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [W-1:0]  rd_data_a,
    output logic [W-1:0]  rd_data_b
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] rda [2];
    logic [W-1:0] rdb [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic SEL = 1'(b);
        logic [W-1:0] mem [DEPTH];

        // Store one word when this bank is the write target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == SEL)) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign rda[b] = mem[rd_addr_a];
        assign rdb[b] = mem[rd_addr_b];
    end

    // Route the two read ports from the selected bank.
    assign rd_data_a = rd_bank ? rda[1] : rda[0];
    assign rd_data_b = rd_bank ? rdb[1] : rdb[0];

endmodule

// File: rtl/cgfft_ctrl.sv
// Module cgfft_ctrl
// Sequences the three phases: load, compute and drain. It produces the
// buffer addresses, bank selects, twiddle index and branch select. Load and
// drain take N cycles each, and every pass takes N cycles: cycle c handles
// butterfly c/2 and writes position c. It assumes N_LOG2 >= 2.
module cgfft_ctrl #(
    parameter int N_LOG2    = 4,
    parameter bit NAT_ORDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              wr_en,
    output logic              wr_load,
    output logic              wr_bank,
    output logic [N_LOG2-1:0] wr_addr,
    output logic              rd_bank,
    output logic [N_LOG2-1:0] rd_addr_a,
    output logic [N_LOG2-1:0] rd_addr_b,
    output logic [N_LOG2-2:0] tw_idx,
    output logic              take_diff,
    output logic              drain_en,
    output logic              drain_last
);
    import cgfft_pkg::*;

    localparam int AW = N_LOG2;
    localparam int SW = $clog2(N_LOG2 + 1);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};
    localparam logic [SW-1:0] LAST_STAGE = SW'(N_LOG2 - 1);
    localparam logic FINAL_BANK = 1'(N_LOG2 % 2);

    phase_t        phase;
    logic [AW-1:0] cnt;
    logic [SW-1:0] stage;
    logic [AW-2:0] bfly;
    logic [AW-2:0] tw_mask;
    logic [AW-1:0] drain_addr;

    // Phase, position counter and pass counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_LOAD;
            cnt   <= '0;
            stage <= '0;
        end else begin
            case (phase)
                PH_LOAD: begin
                    if (in_valid) begin
                        cnt   <= cnt + 1'b1;
                        stage <= '0;
                        if (cnt == LAST) phase <= PH_CALC;
                    end
                end
                PH_CALC: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        if (stage == LAST_STAGE) phase <= PH_DRAIN;
                        else                     stage <= stage + 1'b1;
                    end
                end
                PH_DRAIN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) phase <= PH_LOAD;
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    // Output read address: bit-reversed position or straight position.
    if (NAT_ORDER) begin : g_nat
        for (genvar i = 0; i < AW; i++) begin : g_rev
            assign drain_addr[i] = cnt[AW-1-i];
        end
    end else begin : g_raw
        assign drain_addr = cnt;
    end

    // Butterfly number and twiddle index (low pass bits cleared).
    always_comb begin
        bfly    = cnt[AW-1:1];
        tw_mask = {(AW-1){1'b1}} << stage;
        tw_idx  = bfly & tw_mask;
    end

    // Per-phase buffer control.
    always_comb begin
        in_ready   = (phase == PH_LOAD);
        wr_load    = (phase == PH_LOAD);
        wr_en      = ((phase == PH_LOAD) && in_valid) || (phase == PH_CALC);
        wr_bank    = (phase == PH_LOAD) ? 1'b0 : ~stage[0];
        wr_addr    = cnt;
        rd_bank    = (phase == PH_CALC) ? stage[0] : FINAL_BANK;
        rd_addr_a  = (phase == PH_CALC) ? {1'b0, bfly} : drain_addr;
        rd_addr_b  = {1'b1, bfly};
        take_diff  = cnt[0];
        drain_en   = (phase == PH_DRAIN);
        drain_last = (cnt == LAST);
    end

endmodule

// File: rtl/cgfft_core.sv
// Module cgfft_core
// Top of the constant-geometry radix-2 FFT engine. It links the controller,
// the ping-pong buffers, the twiddle table and the shared butterfly, and it
// registers the result port. Input samples are sign-extended to the full
// output width when they are loaded, so no pass ever truncates.
module cgfft_core #(
    parameter int  N_LOG2    = 4,
    parameter int  DW        = 8,
    parameter int  TW        = 10,
    parameter bit  NAT_ORDER = 1'b1,
    localparam int OW        = DW + N_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic                 out_last,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im
);
    localparam int AW = N_LOG2;
    localparam int WW = 2 * OW;

    logic              wr_en, wr_load, wr_bank, rd_bank;
    logic [AW-1:0]     wr_addr, rd_addr_a, rd_addr_b;
    logic [AW-2:0]     tw_idx;
    logic              take_diff, drain_en, drain_last;
    logic [WW-1:0]     wr_data, rd_data_a, rd_data_b;
    logic signed [OW-1:0] ld_re, ld_im, a_re, a_im, b_re, b_im, y_re, y_im;
    logic signed [TW-1:0] w_re, w_im;

    cgfft_ctrl #(
        .N_LOG2    (N_LOG2),
        .NAT_ORDER (NAT_ORDER)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_load    (wr_load),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .rd_bank    (rd_bank),
        .rd_addr_a  (rd_addr_a),
        .rd_addr_b  (rd_addr_b),
        .tw_idx     (tw_idx),
        .take_diff  (take_diff),
        .drain_en   (drain_en),
        .drain_last (drain_last)
    );

    cgfft_pingpong #(
        .AW (AW),
        .W  (WW)
    ) u_buf (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_bank   (rd_bank),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    cgfft_twiddle_rom #(
        .N_LOG2 (N_LOG2),
        .TW     (TW)
    ) u_rom (
        .idx  (tw_idx),
        .w_re (w_re),
        .w_im (w_im)
    );

    cgfft_butterfly #(
        .OW (OW),
        .TW (TW)
    ) u_bfly (
        .a_re      (a_re),
        .a_im      (a_im),
        .b_re      (b_re),
        .b_im      (b_im),
        .w_re      (w_re),
        .w_im      (w_im),
        .take_diff (take_diff),
        .y_re      (y_re),
        .y_im      (y_im)
    );

    // Unpack the read words and sign-extend the incoming sample.
    always_comb begin
        a_re  = rd_data_a[WW-1:OW];
        a_im  = rd_data_a[OW-1:0];
        b_re  = rd_data_b[WW-1:OW];
        b_im  = rd_data_b[OW-1:0];
        ld_re = {{N_LOG2{in_re[DW-1]}}, in_re};
        ld_im = {{N_LOG2{in_im[DW-1]}}, in_im};
    end

    // The write word comes from the input port while loading, otherwise from the butterfly.
    assign wr_data = wr_load ? {ld_re, ld_im} : {y_re, y_im};

    // Registered result port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= drain_en;
            out_last  <= drain_en && drain_last;
            if (drain_en) begin
                out_re <= a_re;
                out_im <= a_im;
            end
        end
    end

endmodule

// File: rtl/cgfft_core_chk.sv
// Module cgfft_core_chk
// Protocol checker bound to cgfft_core. It counts accepted inputs and
// delivered results on its own, and it checks the handshake, framing and
// reset rules at the ports.
module cgfft_core_chk #(
    parameter int N_LOG2 = 4
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_last
);
    localparam int N  = 1 << N_LOG2;
    localparam int CW = N_LOG2 + 1;
    localparam logic [CW-1:0] TOP = CW'(N - 1);

    logic [CW-1:0] acc_cnt;
    logic [CW-1:0] out_cnt;

    // Count accepted input samples within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_cnt <= '0;
        else if (in_valid && in_ready) acc_cnt <= (acc_cnt == TOP) ? '0 : acc_cnt + 1'b1;
    end

    // Count delivered results within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) out_cnt <= '0;
        else if (out_valid) out_cnt <= out_last ? '0 : out_cnt + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (in_ready && !out_valid && !out_last)); // R1
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && acc_cnt == TOP) |=> !in_ready); // R2
    AST_NO_READY_OUT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_last) |-> !in_ready); // R2
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_valid); // R4
    AST_LAST_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_cnt == TOP) |-> out_last); // R4
    AST_OUT_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_last) |=> out_valid); // R4
    AST_READY_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> in_ready); // R8

endmodule

bind cgfft_core cgfft_core_chk #(
    .N_LOG2 (N_LOG2)
) u_cgfft_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/cgfft_core_harness.sv
// Module cgfft_core_harness
// Drives one cgfft_core instance through directed scenarios. It computes the
// expected results from the requirements and reports its own check and error
// counts. The clock comes from the bench; the reset is driven here.
module cgfft_core_harness #(
    parameter int N_LOG2    = 4,
    parameter bit NAT_ORDER = 1'b1
) (
    input  logic clk,
    output logic done,
    output int   n_chk,
    output int   n_err
);
    localparam int L  = N_LOG2;
    localparam int N  = 1 << L;
    localparam int DW = 8;
    localparam int TW = 10;
    localparam int OW = DW + L;
    localparam int QS = 1 << (TW - 2);

    logic                 rst_n;
    logic                 in_valid;
    logic                 in_ready;
    logic signed [DW-1:0] in_re, in_im;
    logic                 out_valid, out_last;
    logic signed [OW-1:0] out_re, out_im;

    int xr [N];
    int xi [N];
    int er [N];
    int ei [N];
    int gr [N];
    int gi [N];
    int seed;

    cgfft_core #(
        .N_LOG2    (N_LOG2),
        .DW        (DW),
        .TW        (TW),
        .NAT_ORDER (NAT_ORDER)
    ) u_cgfft_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s N=%0d %s: actual %0d expected %0d", req, N, what, act, exp);
        end
    endtask

    function automatic int brev(input int v);
        int r = 0;
        for (int b = 0; b < L; b++) if (v[b]) r |= (1 << (L - 1 - b));
        return r;
    endfunction

    // Bit-exact model of the pass structure of R5, with the output order of R7.
    task automatic model();
        int cr [N];
        int ci [N];
        int nr [N];
        int ni [N];
        for (int i = 0; i < N; i++) begin cr[i] = xr[i]; ci[i] = xi[i]; end
        for (int s = 0; s < L; s++) begin
            for (int k = 0; k < N / 2; k++) begin
                int dr, di, wr, wi, j, pr, pi;
                real ang;
                j   = (k >> s) << s;
                ang = 6.283185307179586 * real'(j) / real'(N);
                wr  = $rtoi($floor(real'(QS) * $cos(ang) + 0.5));
                wi  = $rtoi($floor(-real'(QS) * $sin(ang) + 0.5));
                nr[2*k] = cr[k] + cr[k+N/2];
                ni[2*k] = ci[k] + ci[k+N/2];
                dr = cr[k] - cr[k+N/2];
                di = ci[k] - ci[k+N/2];
                pr = dr * wr - di * wi;
                pi = dr * wi + di * wr;
                nr[2*k+1] = (pr + (1 << (TW - 3))) >>> (TW - 2);
                ni[2*k+1] = (pi + (1 << (TW - 3))) >>> (TW - 2);
            end
            for (int i = 0; i < N; i++) begin cr[i] = nr[i]; ci[i] = ni[i]; end
        end
        for (int m = 0; m < N; m++) begin
            int src;
            src   = NAT_ORDER ? brev(m) : m;
            er[m] = cr[src];
            ei[m] = ci[src];
        end
    endtask

    // Loads xr/xi, waits for the results and checks framing, timing and values.
    task automatic run_frame(input string req, input bit garbage);
        int edges;
        model();
        chk("R2", "in_ready before load", int'(in_ready), 1);
        for (int i = 0; i < N; i++) begin
            in_valid = 1'b1;
            in_re    = DW'(xr[i]);
            in_im    = DW'(xi[i]);
            @(negedge clk);
        end
        chk("R2", "in_ready after N-th sample", int'(in_ready), 0);
        in_valid = garbage;
        in_re    = 8'sd77;
        in_im    = -8'sd55;
        edges    = 0;
        while (!out_valid && edges < 5000) begin
            @(negedge clk);
            edges++;
        end
        in_valid = 1'b0;
        chk("R4", "edges to first result", edges, L * N + 1);
        for (int m = 0; m < N; m++) begin
            chk("R4", "out_valid in result run", int'(out_valid), 1);
            chk("R4", "out_last position", int'(out_last), int'(m == N - 1));
            chk("R8", "in_ready during drain", int'(in_ready), int'(m == N - 1));
            gr[m] = int'(out_re);
            gi[m] = int'(out_im);
            chk(req, $sformatf("re[%0d]", m), gr[m], er[m]);
            chk(req, $sformatf("im[%0d]", m), gi[m], ei[m]);
            if (m < N - 1) @(negedge clk);
        end
    endtask

    function automatic int rnd90();
        seed = seed * 1103515245 + 12345;
        return ((seed >> 16) & 255) % 181 - 90;
    endfunction

    task automatic t_reset_state();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "in_ready after reset", int'(in_ready), 1);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "out_last after reset", int'(out_last), 0);
    endtask

    task automatic t_impulse();
        for (int i = 0; i < N; i++) begin xr[i] = 0; xi[i] = 0; end
        xr[0] = 100;
        run_frame("R5", 1'b0);
        for (int m = 0; m < N; m++) begin
            chk("R5", "impulse flat re", gr[m], 100);
            chk("R5", "impulse flat im", gi[m], 0);
        end
    endtask

    task automatic t_dc_fullscale();
        for (int i = 0; i < N; i++) begin xr[i] = -128; xi[i] = 0; end
        run_frame("R6", 1'b0);
        chk("R6", "bin0 unscaled", gr[0], -128 * N);
        for (int m = 1; m < N; m++) chk("R6", "other bins zero", gr[m], 0);
    endtask

    task automatic t_tone_order();
        int best, bidx, mag;
        for (int i = 0; i < N; i++) begin
            real ang;
            ang = 6.283185307179586 * real'(i) / real'(N);
            xr[i] = $rtoi($floor(80.0 * $cos(ang) + 0.5));
            xi[i] = $rtoi($floor(80.0 * $sin(ang) + 0.5));
        end
        run_frame("R3", 1'b1);
        best = -1;
        bidx = -1;
        for (int m = 0; m < N; m++) begin
            mag = (gr[m] < 0 ? -gr[m] : gr[m]) + (gi[m] < 0 ? -gi[m] : gi[m]);
            if (mag > best) begin best = mag; bidx = m; end
        end
        chk("R7", "tone position", bidx, NAT_ORDER ? 1 : N / 2);
    endtask

    task automatic t_random();
        for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < N; i++) begin xr[i] = rnd90(); xi[i] = rnd90(); end
            run_frame("R5", f[0]);
        end
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < N / 2; i++) begin
            in_valid = 1'b1;
            in_re    = 8'sd33;
            in_im    = -8'sd21;
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n    = 1'b1;
        chk("R9", "in_ready after mid reset", int'(in_ready), 1);
        chk("R9", "out_valid after mid reset", int'(out_valid), 0);
        for (int i = 0; i < N; i++) begin xr[i] = rnd90(); xi[i] = rnd90(); end
        run_frame("R9", 1'b0);
    endtask

    initial begin
        n_chk    = 0;
        n_err    = 0;
        done     = 1'b0;
        seed     = 12345 + N;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_re    = '0;
        in_im    = '0;
        t_reset_state();
        t_impulse();
        t_dc_fullscale();
        t_tone_order();
        t_random();
        t_reset_mid();
        done = 1'b1;
    end

endmodule

// File: tb/cgfft_core_bench.sv
// Module cgfft_core_bench
// Generates the clock, runs a 16-point natural-order harness and an 8-point
// bit-reversed harness, guards the run with a watchdog and prints the totals.
module cgfft_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk;
    logic d16, d8;
    int   c16, e16, c8, e8;

    cgfft_core_harness #(.N_LOG2(4), .NAT_ORDER(1'b1)) u_h16 (
        .clk (clk), .done (d16), .n_chk (c16), .n_err (e16)
    );

    cgfft_core_harness #(.N_LOG2(3), .NAT_ORDER(1'b0)) u_h8 (
        .clk (clk), .done (d8), .n_chk (c8), .n_err (e8)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        int cyc = 0;
        int wd  = 0;
        @(posedge clk);
        while (!(d16 && d8) && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= WATCHDOG) begin
            wd = 1;
            $display("FAIL R4 watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
        end
        $display("CHECKS %0d ERRORS %0d", c16 + c8 + wd, e16 + e8 + wd);
        $finish;
    end

endmodule